// File: doc/BRIEF.md
# Oscillator Control PWM DAC Driver

This block turns a signed loop-filter value into an unsigned offset-binary code and uses that code to set the duty cycle of one PWM pin. The pin's filtered average steers a voltage-controlled oscillator. The code can come from one of five sources, selected by a 3-bit field:

- mid-scale,
- the loop filter,
- the slowest end of the range,
- the fastest end of the range,
- a value written by a CPU.

A hold input freezes the loop-filter code. Two override inputs pin the output high or low. An enable input controls the pin driver, and an external tri-state buffer takes the driver enable.

The PWM compares a free-running counter with the upper bits of the code. The counter advances once per prescaler period. By default that period is twice a build-time divide factor. A bypass input shortens it to two clocks, so the counter then runs at half the clock rate. The code in use is always available for status readback.

Top module: `vpd_top`

## Requirements
- R1: Source select 000 gives code 0x800000 (mid frequency). The reserved selects 101, 110 and 111 also give 0x800000.
- R2: Source select 001 gives the loop-filter value with its most significant bit inverted. For example, 0xFFFFFF (-1) gives 0x7FFFFF and 0x000001 gives 0x800001.
- R3: Source select 010 gives 0x000000 (slowest). Source select 011 gives 0xFFFFFF (fastest).
- R4: Source select 100 gives the 24-bit CPU value unchanged.
- R5: While hold is 1 and select is 001, the code keeps its value whatever the filter input does. With any other select, hold has no effect.
- R6: The code output reflects the inputs one clock after they are sampled. After reset it is 0x800000.
- R7: The pin is registered and reads 0 after reset. It is high while the PWM counter is below the code's top 8 bits. The counter advances once every 2*CLK_DIV clocks, so a code of 0x800000 gives exactly half of a 256-step period high.
- R8: With bypass set, the PWM counter advances every 2 clocks, so a full period takes 512 clocks.
- R9: Force-high sets the pin to 1 on the next clock. Force-low sets it to 0. When both are set, the pin is 1.
- R10: The pin output enable follows the enable input one clock later and is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| filt_val | input | 24 | Signed two's-complement loop-filter value |
| src_sel | input | 3 | Code source select |
| hold | input | 1 | Freeze the code while the loop-filter source is selected |
| force_lo | input | 1 | Force the pin low |
| force_hi | input | 1 | Force the pin high; wins over force_lo |
| out_en | input | 1 | Pin driver enable request |
| div_bypass | input | 1 | Skip the build-time PWM clock divider |
| cpu_code | input | 24 | Offset-binary code used with select 100 |
| pwm_pin | output | 1 | PWM pin value |
| pwm_oe | output | 1 | Pin driver enable; 0 means high-impedance |
| code_now | output | 24 | Offset-binary code currently in use |

## Verification
The bench walks every select value, including the reserved ones, and feeds the loop-filter source with negative, positive, zero and extreme inputs. This shows whether the conversion inverts only the top bit, as opposed to negating the value or passing it through. Hold is tried both with the loop-filter source and with the CPU source, which separates freezing the code from ignoring the hold input. Duty is measured over whole PWM periods with and without bypass, which exposes both comparator and divider faults. Forces are applied singly and together to expose a wrong priority.

// File: rtl/vpd_pkg.sv
package vpd_pkg;
  typedef enum logic [2:0] {
    SRC_MID  = 3'b000,
    SRC_LOOP = 3'b001,
    SRC_NEG  = 3'b010,
    SRC_POS  = 3'b011,
    SRC_CPU  = 3'b100
  } src_e;
endpackage

// File: rtl/vpd_code_sel.sv
module vpd_code_sel
  import vpd_pkg::*;
#(
  parameter int CODE_W = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] filt_val,
  input  logic [2:0]        src_sel,
  input  logic              hold,
  input  logic [CODE_W-1:0] cpu_code,
  output logic [CODE_W-1:0] code_q
);
  localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] pick;
  logic              frozen;

  always_comb begin
    unique case (src_sel)
      SRC_LOOP: pick = {~filt_val[CODE_W-1], filt_val[CODE_W-2:0]};
      SRC_NEG:  pick = '0;
      SRC_POS:  pick = '1;
      SRC_CPU:  pick = cpu_code;
      default:  pick = MID_CODE;
    endcase
  end

  assign frozen = hold && (src_sel == SRC_LOOP);

  always_ff @(posedge clk) begin
    if (rst)          code_q <= MID_CODE;
    else if (!frozen) code_q <= pick;
  end

  // R5
  hold_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && src_sel == SRC_LOOP) |=> $stable(code_q));
  // R3
  full_neg_chk: assert property (@(posedge clk) disable iff (rst)
    (src_sel == SRC_NEG) |=> (code_q == '0));
  // R1
  reserved_mid_chk: assert property (@(posedge clk) disable iff (rst)
    (src_sel > SRC_CPU) |=> (code_q == MID_CODE));
endmodule

// File: rtl/vpd_prescale.sv
module vpd_prescale #(
  parameter int CLK_DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic div_bypass,
  output logic tick
);
  localparam int SLOW_PER = 2 * CLK_DIV;
  localparam int CNT_W    = $clog2(SLOW_PER + 1);
  localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(SLOW_PER - 1);
  localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last;

  assign last = div_bypass ? FAST_LAST : SLOW_LAST;
  assign tick = (cnt_q >= last);

  always_ff @(posedge clk) begin
    if (rst)       cnt_q <= '0;
    else if (tick) cnt_q <= '0;
    else           cnt_q <= cnt_q + 1'b1;
  end

  // R8
  bypass_window_chk: assert property (@(posedge clk) disable iff (rst)
    (div_bypass && cnt_q <= FAST_LAST) |=> (cnt_q <= FAST_LAST));
  // R7
  slow_range_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (cnt_q <= SLOW_LAST));
endmodule

// File: rtl/vpd_pwm_core.sv
module vpd_pwm_core #(
  parameter int PWM_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                tick,
  input  logic [PWM_BITS-1:0] duty,
  input  logic                force_lo,
  input  logic                force_hi,
  input  logic                out_en,
  output logic                pin_q,
  output logic                oe_q
);
  logic [PWM_BITS-1:0] pc_q;

  always_ff @(posedge clk) begin
    if (rst)       pc_q <= '0;
    else if (tick) pc_q <= pc_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin_q <= 1'b0;
      oe_q  <= 1'b0;
    end else begin
      oe_q <= out_en;
      if (force_hi)      pin_q <= 1'b1;
      else if (force_lo) pin_q <= 1'b0;
      else               pin_q <= (pc_q < duty);
    end
  end

  // R7
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !tick |=> $stable(pc_q));
  // R9
  force_hi_chk: assert property (@(posedge clk) disable iff (rst)
    force_hi |=> pin_q);
  // R9
  force_lo_chk: assert property (@(posedge clk) disable iff (rst)
    (force_lo && !force_hi) |=> !pin_q);
  // R10
  oe_follow_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (oe_q == $past(out_en)));
endmodule

// File: rtl/vpd_top.sv
module vpd_top #(
  parameter int CODE_W   = 24,
  parameter int PWM_BITS = 8,
  parameter int CLK_DIV  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [CODE_W-1:0] filt_val,
  input  logic [2:0]        src_sel,
  input  logic              hold,
  input  logic              force_lo,
  input  logic              force_hi,
  input  logic              out_en,
  input  logic              div_bypass,
  input  logic [CODE_W-1:0] cpu_code,
  output logic              pwm_pin,
  output logic              pwm_oe,
  output logic [CODE_W-1:0] code_now
);
  logic tick;

  vpd_code_sel #(.CODE_W(CODE_W)) u_sel (
    .clk(clk), .rst(rst), .filt_val(filt_val), .src_sel(src_sel),
    .hold(hold), .cpu_code(cpu_code), .code_q(code_now)
  );

  vpd_prescale #(.CLK_DIV(CLK_DIV)) u_pre (
    .clk(clk), .rst(rst), .div_bypass(div_bypass), .tick(tick)
  );

  vpd_pwm_core #(.PWM_BITS(PWM_BITS)) u_pwm (
    .clk(clk), .rst(rst), .tick(tick),
    .duty(code_now[CODE_W-1 -: PWM_BITS]),
    .force_lo(force_lo), .force_hi(force_hi), .out_en(out_en),
    .pin_q(pwm_pin), .oe_q(pwm_oe)
  );
endmodule

// File: tb/sim_vpd_top.sv
`timescale 1ns/1ps
module sim_vpd_top;
  localparam int DIV = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] filt_val = '0;
  logic [2:0]  src_sel = '0;
  logic        hold = 0, force_lo = 0, force_hi = 0, out_en = 0, div_bypass = 0;
  logic [23:0] cpu_code = '0;
  logic        pwm_pin, pwm_oe;
  logic [23:0] code_now;

  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  vpd_top u0 (
    .clk(clk), .rst(rst), .filt_val(filt_val), .src_sel(src_sel), .hold(hold),
    .force_lo(force_lo), .force_hi(force_hi), .out_en(out_en),
    .div_bypass(div_bypass), .cpu_code(cpu_code),
    .pwm_pin(pwm_pin), .pwm_oe(pwm_oe), .code_now(code_now)
  );

  // Behavioural reference model
  int m_code, m_pre, m_pc, m_pin, m_oe;

  function automatic int want_code(input logic [2:0] s, input logic [23:0] f,
                                   input logic [23:0] c);
    case (s)
      3'd1:    return int'(f ^ 24'h800000);
      3'd2:    return 0;
      3'd3:    return 24'hFFFFFF;
      3'd4:    return int'(c);
      default: return 24'h800000;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_code = 24'h800000; m_pre = 0; m_pc = 0; m_pin = 0; m_oe = 0;
    end else begin
      int nxt_pin, per;
      if (force_hi)      nxt_pin = 1;
      else if (force_lo) nxt_pin = 0;
      else               nxt_pin = (m_pc < (m_code >> 16)) ? 1 : 0;
      m_oe = out_en ? 1 : 0;
      if (!(src_sel == 3'd1 && hold)) m_code = want_code(src_sel, filt_val, cpu_code);
      per = div_bypass ? 2 : 2 * DIV;
      if (m_pre >= per - 1) begin m_pre = 0; m_pc = (m_pc + 1) % 256; end
      else m_pre = m_pre + 1;
      m_pin = nxt_pin;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Model comparison on every clock, sampled at the falling edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1/R2/R3/R4/R5/R6 code", int'(code_now), m_code);
      chk("R7/R8/R9 pin", int'(pwm_pin), m_pin);
      chk("R10 oe", int'(pwm_oe), m_oe);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic high_count(input int win, output int hc);
    hc = 0;
    repeat (win) begin @(negedge clk); if (pwm_pin) hc++; end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int hc;
    step(5);
    chk("R6 reset code", int'(code_now), 24'h800000);
    chk("R7 reset pin", int'(pwm_pin), 0);
    chk("R10 reset oe", int'(pwm_oe), 0);
    rst = 0;
    step(2);
    src_sel = 3'd0; step(2); chk("R1 mid", int'(code_now), 24'h800000);
    src_sel = 3'd1; filt_val = 24'hFFFFFF; step(2); chk("R2 minus one", int'(code_now), 24'h7FFFFF);
    filt_val = 24'h000001; step(2); chk("R2 plus one", int'(code_now), 24'h800001);
    filt_val = 24'h800000; step(2); chk("R2 most negative", int'(code_now), 24'h000000);
    filt_val = 24'h7FFFFF; step(2); chk("R2 most positive", int'(code_now), 24'hFFFFFF);
    src_sel = 3'd2; step(2); chk("R3 slowest", int'(code_now), 0);
    src_sel = 3'd3; step(2); chk("R3 fastest", int'(code_now), 24'hFFFFFF);
    cpu_code = 24'h3C5A69; src_sel = 3'd4; step(2); chk("R4 cpu", int'(code_now), 24'h3C5A69);
    for (int s = 5; s < 8; s++) begin
      src_sel = 3'(s); step(2); chk("R1 reserved", int'(code_now), 24'h800000);
    end
    // hold with loop source
    src_sel = 3'd1; filt_val = 24'h123456; step(2);
    hold = 1; filt_val = 24'hABCDEF; step(4);
    chk("R5 hold frozen", int'(code_now), 24'h923456);
    hold = 0; step(1); chk("R6 one clock latency", int'(code_now), 24'h2BCDEF);
    // hold with cpu source has no effect
    src_sel = 3'd4; hold = 1; cpu_code = 24'h00FF00; step(2);
    chk("R5 hold ignored", int'(code_now), 24'h00FF00);
    hold = 0;
    // forces
    force_hi = 1; step(2); chk("R9 force high", int'(pwm_pin), 1);
    force_lo = 1; step(2); chk("R9 both set", int'(pwm_pin), 1);
    force_hi = 0; step(2); chk("R9 force low", int'(pwm_pin), 0);
    force_lo = 0;
    out_en = 1; step(2); chk("R10 enable", int'(pwm_oe), 1);
    out_en = 0; step(2); chk("R10 disable", int'(pwm_oe), 0);
    // duty measurements
    src_sel = 3'd0; step(2);
    high_count(256 * 2 * DIV, hc); chk("R7 half duty divided", hc, 128 * 2 * DIV);
    div_bypass = 1; step(2);
    high_count(512, hc); chk("R8 half duty bypassed", hc, 256);
    src_sel = 3'd2; step(4);
    high_count(512, hc); chk("R7 zero code never high", hc, 0);
    src_sel = 3'd3; step(2);
    high_count(512, hc); chk("R8 full code duty", hc, 510);
    div_bypass = 0; step(3);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule